// File: doc/BRIEF.md
# Reloadable Timer Pair with Toggle Output

This block is the timer unit of a small microcontroller. An 8-bit prescaler feeds an 8-bit timer 1. A second 8-bit timer 2 counts from a choice of sources. Each counter counts down on enabled ticks. When it reaches zero, the next tick reloads it from its own 8-bit latch. Each underflow of timer 1 and timer 2 raises a one-cycle interrupt request.

Timer 2 also drives a toggle flip-flop. When the output is enabled, the flip-flop takes over a shared port pin as a pulse output. A polarity bit sets the level the flip-flop starts from. When the output is disabled, the pin goes back to plain port behaviour.

The CPU reaches the block through a simple register bus. A write is taken on the clock edge while `bus_wr` is high. Read data is combinational from `bus_addr`. All logic runs on one clock. The slow clocks and the external timer A underflow arrive as one-cycle enable strobes. The bus has no back-pressure and no stream interface: every write completes in the cycle it is presented.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the counter addresses 0 (prescaler), 1 (timer 1) and 2 (timer 2) read 0xFF, and the mode register (address 3) and the source register (address 4) read 0x00. Both interrupt outputs are low, and the pin follows the port inputs.
- R2: Each enabled tick decrements a counter. A tick at count 0 reloads the counter from its latch, so the underflow period is latch+1 ticks.
- R3: An underflow of timer 1 or timer 2 produces a one-cycle high pulse on its interrupt output. The pulse appears in the cycle after the underflowing tick.
- R4: A write to the prescaler or timer 1, and a write to timer 2 while mode bit 4 is 0, loads both the latch and the counter. A read then returns the written value.
- R5: While mode bit 4 is 1, a write to timer 2 updates only its latch. The counter keeps its value and takes the new value at its next reload.
- R6: While mode bit 1 (timer 2 stop) is 1, timer 2 holds its count.
- R7: Source bit 0 selects the prescaler tick: 0 selects `div16_tick` and 1 selects `sub_tick`. Timer 1 counts prescaler underflows.
- R8: Source bits 2:1 select the timer 2 tick: 00 selects timer 1 underflow, 01 selects `sysdiv_tick`, 10 selects `ta_uf` and 11 selects nothing.
- R9: While mode bit 2 (output valid) is 1 and timer 2 runs, `pin_out` inverts on each timer 2 underflow and `pin_oe` is 1.
- R10: While the output is not valid or timer 2 is stopped, the flip-flop holds its start level. Mode bit 3 = 0 gives a start level of 1, and bit 3 = 1 gives 0.
- R11: While mode bit 2 is 0, `pin_out` equals `port_q` and `pin_oe` equals `port_dir`.
- R12: Mode bits 5 and 6 drive `ta_wr_latch_only` and `ta_stop`. Mode bits 0 and 7 and source bits 7:3 read back as 0.
- R13: A counter address reads the live count, not the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| div16_tick | input | 1 | Source clock divided by 16, enable strobe |
| sub_tick | input | 1 | Sub-clock enable strobe |
| sysdiv_tick | input | 1 | Divided system clock strobe for timer 2 |
| ta_uf | input | 1 | Timer A underflow strobe |
| port_q | input | 1 | Port latch bit for the shared pin |
| port_dir | input | 1 | Port direction bit for the shared pin |
| pin_out | output | 1 | Shared pin output value |
| pin_oe | output | 1 | Shared pin output enable |
| t1_irq | output | 1 | Timer 1 interrupt request pulse |
| t2_irq | output | 1 | Timer 2 interrupt request pulse |
| ta_stop | output | 1 | Timer A stop control |
| ta_wr_latch_only | output | 1 | Timer A write-control mode |

## Verification
The bench measures the interval between interrupt pulses and compares it with the period computed from the latch values:
- **Timer 2 sweep.** Timer 2 runs from a constant strobe across a sweep of latch values. This separates an off-by-one reload from a correct latch+1 period.
- **Prescaler and timer 1 grid.** The prescaler and timer 1 run over a grid of latch pairs, whose product periods expose a broken cascade.
- **Timer 2 sources.** Each timer 2 source code is tried with only the wanted strobe active, so a swapped selection shows up as a missing or wrong period.
- **Write control and the pin.** Latch-only writes and stopped intervals are compared with write-both behaviour. The pin level is sampled at successive underflows under both polarities.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_PRE  = 3'd0;
  localparam logic [AW-1:0] A_T1   = 3'd1;
  localparam logic [AW-1:0] A_T2   = 3'd2;
  localparam logic [AW-1:0] A_MODE = 3'd3;
  localparam logic [AW-1:0] A_SRC  = 3'd4;

  // mode register bit positions
  localparam int M_T2_STOP = 1;
  localparam int M_OUT_EN  = 2;
  localparam int M_POL     = 3;
  localparam int M_T2_WLO  = 4;
  localparam int M_TA_WLO  = 5;
  localparam int M_TA_STOP = 6;
  localparam logic [DW-1:0] MODE_MASK = 8'h7E;
  localparam logic [DW-1:0] SRC_MASK  = 8'h07;

  typedef enum logic [1:0] {
    T2_FROM_T1  = 2'b00,
    T2_FROM_DIV = 2'b01,
    T2_FROM_TA  = 2'b10,
    T2_NONE     = 2'b11
  } t2_src_e;
endpackage

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic         latch_only,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] lat,
  output logic         uf
);
  logic load_cnt;
  assign load_cnt = wr && !latch_only;
  assign uf = tick && (cnt == '0) && !load_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= RST_VAL;
      lat <= RST_VAL;
    end else begin
      if (wr) lat <= wdata;
      if (load_cnt)  cnt <= wdata;
      else if (tick) cnt <= (cnt == '0) ? lat : cnt - 1'b1;
    end
  end

  AST_RELOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == '0 && !wr) |=> cnt == $past(lat)); // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !wr) |=> cnt == $past(cnt) - 1'b1); // R2
  AST_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !latch_only) |=> (cnt == $past(wdata) && lat == $past(wdata))); // R4
  AST_LATCH_ONLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && latch_only && !tick) |=> $stable(cnt)); // R5
endmodule

// File: rtl/tmr_toggle.sv
module tmr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic out_valid,
  input  logic pol,
  input  logic uf,
  input  logic port_q,
  input  logic port_dir,
  output logic pin_out,
  output logic pin_oe
);
  logic tff;

  always_ff @(posedge clk) begin
    if (!rst_n)   tff <= 1'b1;
    else if (!en) tff <= !pol;
    else if (uf)  tff <= !tff;
  end

  assign pin_out = out_valid ? tff : port_q;
  assign pin_oe  = out_valid ? 1'b1 : port_dir;

  AST_START_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> tff == !$past(pol)); // R10
  AST_TOGGLE_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uf) |=> tff == !$past(tff)); // R9
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          div16_tick,
  input  logic          sub_tick,
  input  logic          sysdiv_tick,
  input  logic          ta_uf,
  input  logic          port_q,
  input  logic          port_dir,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          t1_irq,
  output logic          t2_irq,
  output logic          ta_stop,
  output logic          ta_wr_latch_only
);
  logic [DW-1:0] mode_q, src_q;
  logic [DW-1:0] pre_cnt, t1_cnt, t2_cnt;
  logic [DW-1:0] pre_lat, t1_lat, t2_lat;
  logic pre_tick, t1_tick, t2_tick;
  logic pre_uf, t1_uf, t2_uf;
  logic wr_pre, wr_t1, wr_t2;
  logic t2_stop, t2_run;
  t2_src_e t2_src;

  assign wr_pre = bus_wr && bus_addr == A_PRE;
  assign wr_t1  = bus_wr && bus_addr == A_T1;
  assign wr_t2  = bus_wr && bus_addr == A_T2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      src_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) mode_q <= bus_wdata & MODE_MASK;
      if (bus_addr == A_SRC)  src_q  <= bus_wdata & SRC_MASK;
    end
  end

  assign t2_stop          = mode_q[M_T2_STOP];
  assign t2_run           = !t2_stop;
  assign ta_stop          = mode_q[M_TA_STOP];
  assign ta_wr_latch_only = mode_q[M_TA_WLO];
  assign t2_src           = t2_src_e'(src_q[2:1]);

  assign pre_tick = src_q[0] ? sub_tick : div16_tick;
  assign t1_tick  = pre_uf;

  always_comb begin
    unique case (t2_src)
      T2_FROM_T1:  t2_tick = t1_uf;
      T2_FROM_DIV: t2_tick = sysdiv_tick;
      T2_FROM_TA:  t2_tick = ta_uf;
      default:     t2_tick = 1'b0;
    endcase
    t2_tick = t2_tick && t2_run;
  end

  tmr_downcnt #(.W(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .wr(wr_pre), .latch_only(1'b0),
    .wdata(bus_wdata), .cnt(pre_cnt), .lat(pre_lat), .uf(pre_uf));

  tmr_downcnt #(.W(DW)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(t1_tick), .wr(wr_t1), .latch_only(1'b0),
    .wdata(bus_wdata), .cnt(t1_cnt), .lat(t1_lat), .uf(t1_uf));

  tmr_downcnt #(.W(DW)) u_t2 (
    .clk(clk), .rst_n(rst_n), .tick(t2_tick), .wr(wr_t2),
    .latch_only(mode_q[M_T2_WLO]),
    .wdata(bus_wdata), .cnt(t2_cnt), .lat(t2_lat), .uf(t2_uf));

  tmr_toggle u_tog (
    .clk(clk), .rst_n(rst_n),
    .en(mode_q[M_OUT_EN] && t2_run), .out_valid(mode_q[M_OUT_EN]),
    .pol(mode_q[M_POL]), .uf(t2_uf),
    .port_q(port_q), .port_dir(port_dir),
    .pin_out(pin_out), .pin_oe(pin_oe));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_irq <= 1'b0;
      t2_irq <= 1'b0;
    end else begin
      t1_irq <= t1_uf;
      t2_irq <= t2_uf;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_PRE:   bus_rdata = pre_cnt;
      A_T1:    bus_rdata = t1_cnt;
      A_T2:    bus_rdata = t2_cnt;
      A_MODE:  bus_rdata = mode_q;
      A_SRC:   bus_rdata = src_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_T2_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_stop && !wr_t2) |=> $stable(t2_cnt)); // R6
  AST_IRQ_FOLLOWS_UF: assert property (@(posedge clk) disable iff (!rst_n)
    t2_uf |=> t2_irq); // R3
  AST_UNUSED_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MODE) |=> (mode_q[0] == 1'b0 && mode_q[7] == 1'b0)); // R12
endmodule

// File: tb/tmr_unit_bench.sv
module tmr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic div16_tick = 0, sub_tick = 0, sysdiv_tick = 0, ta_uf = 0;
  logic port_q = 1'b1, port_dir = 1'b0;
  logic pin_out, pin_oe, t1_irq, t2_irq, ta_stop, ta_wr_latch_only;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tmr_unit u_tmr_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div16_tick(div16_tick), .sub_tick(sub_tick), .sysdiv_tick(sysdiv_tick),
    .ta_uf(ta_uf), .port_q(port_q), .port_dir(port_dir),
    .pin_out(pin_out), .pin_oe(pin_oe), .t1_irq(t1_irq), .t2_irq(t2_irq),
    .ta_stop(ta_stop), .ta_wr_latch_only(ta_wr_latch_only));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  // interval in cycles between two consecutive pulses; -1 on timeout
  task automatic period(input bit which_t2, output int per);
    int n;
    per = -1;
    n = 0;
    do begin @(negedge clk); n++; end
    while (!(which_t2 ? t2_irq : t1_irq) && n < 3000);
    if (n >= 3000) return;
    n = 0;
    do begin @(negedge clk); n++; end
    while (!(which_t2 ? t2_irq : t1_irq) && n < 3000);
    if (n < 3000) per = n;
  endtask

  task automatic count_pulses(input bit which_t2, input int len, output int k);
    k = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (which_t2 ? t2_irq : t1_irq) k++;
    end
  endtask

  initial begin
    int v, per, k, lv0, lv1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 prescaler reset", v, 255);
    rd(3'd1, v); chk("R1 timer1 reset", v, 255);
    rd(3'd2, v); chk("R1 timer2 reset", v, 255);
    rd(3'd3, v); chk("R1 mode reset", v, 0);
    rd(3'd4, v); chk("R1 source reset", v, 0);
    chk("R1 irq low", int'(t1_irq) + int'(t2_irq), 0);
    chk("R1 pin follows port", int'(pin_out), 1);
    chk("R1 oe follows dir", int'(pin_oe), 0);

    // R12 unused bits and timer A controls
    wr(3'd3, 8'hFF);
    rd(3'd3, v); chk("R12 mode readback", v, 8'h7E);
    chk("R12 ta_stop", int'(ta_stop), 1);
    chk("R12 ta_wr_latch_only", int'(ta_wr_latch_only), 1);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R12 source readback", v, 8'h07);
    wr(3'd3, 8'h00);
    chk("R12 ta controls clear", int'(ta_stop) + int'(ta_wr_latch_only), 0);

    // R2 R3 timer2 sweep from sysdiv strobe
    wr(3'd4, 8'h02);
    sysdiv_tick = 1'b1;
    for (int L = 0; L < 8; L++) begin
      wr(3'd2, 8'(L));
      period(1'b1, per);
      chk($sformatf("R2 R3 timer2 period latch=%0d", L), per, L + 1);
    end

    // R4 R6 R13 stopped write-both
    wr(3'd3, 8'h02);
    wr(3'd2, 8'h40);
    rd(3'd2, v); chk("R4 write both loads count", v, 8'h40);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R6 stopped count holds", v, 8'h40);

    // R5 R13 latch-only write
    wr(3'd3, 8'h12);
    wr(3'd2, 8'h05);
    rd(3'd2, v); chk("R5 R13 latch-only keeps live count", v, 8'h40);
    wr(3'd3, 8'h10);
    period(1'b1, per);
    chk("R5 new latch used on reload", per, 6);

    // R7 prescaler and timer1 grid
    wr(3'd3, 8'h02);
    sysdiv_tick = 1'b0;
    wr(3'd4, 8'h00);
    div16_tick = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        wr(3'd0, 8'(p));
        wr(3'd1, 8'(q));
        period(1'b0, per);
        chk($sformatf("R7 R2 timer1 period p=%0d q=%0d", p, q), per, (p + 1) * (q + 1));
      end
    end
    wr(3'd4, 8'h01);
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd0);
    count_pulses(1'b0, 40, k);
    chk("R7 sub source ignores div16", k, 0);
    sub_tick = 1'b1;
    period(1'b0, per);
    chk("R7 sub source counts", per, 1);
    sub_tick = 1'b0;

    // R8 timer2 sources
    wr(3'd4, 8'h00);
    wr(3'd0, 8'd0);
    wr(3'd1, 8'd1);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'd2);
    period(1'b1, per);
    chk("R8 source 00 timer1 underflow", per, 6);
    div16_tick = 1'b0;
    ta_uf = 1'b1;
    wr(3'd4, 8'h04);
    wr(3'd2, 8'd2);
    period(1'b1, per);
    chk("R8 source 10 timer A", per, 3);
    wr(3'd4, 8'h06);
    count_pulses(1'b1, 40, k);
    chk("R8 source 11 none", k, 0);
    ta_uf = 1'b0;

    // R10 start level, R9 toggling
    wr(3'd4, 8'h02);
    sysdiv_tick = 1'b1;
    wr(3'd3, 8'h06);
    @(negedge clk);
    chk("R10 pol0 start high", int'(pin_out), 1);
    chk("R9 oe when valid", int'(pin_oe), 1);
    wr(3'd3, 8'h0E);
    @(negedge clk);
    chk("R10 pol1 start low", int'(pin_out), 0);
    wr(3'd3, 8'h06);
    wr(3'd2, 8'd1);
    wr(3'd3, 8'h04);
    do @(negedge clk); while (!t2_irq);
    lv0 = int'(pin_out);
    chk("R9 first toggle from high", lv0, 0);
    do @(negedge clk); while (!t2_irq);
    lv1 = int'(pin_out);
    chk("R9 second toggle", lv1, 1);
    wr(3'd3, 8'h00);

    // R11 port passthrough
    port_q = 1'b0; port_dir = 1'b1;
    @(negedge clk);
    chk("R11 pin=port_q", int'(pin_out), 0);
    chk("R11 oe=port_dir", int'(pin_oe), 1);
    port_q = 1'b1; port_dir = 1'b0;
    @(negedge clk);
    chk("R11 pin=port_q high", int'(pin_out), 1);
    chk("R11 oe=port_dir low", int'(pin_oe), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule